// File: doc/BRIEF.md
# SIMD XOR-Rotate Logic Unit

This unit performs one of four bitwise operations on a 128-bit vector in a single registered step. The operations are the ones that dominate the inner rounds of sponge-style hash functions: a fixed one-bit left rotate of one operand merged by XOR into another, an XOR followed by a per-element right rotate of programmable size and amount, a three-input XOR, and an XOR with a masked operand (`a ^ (b & ~c)`).

The caller presents an operation code, an element-size code, a rotate amount and three source vectors together with a valid strobe. One clock later the result appears with its own valid flag. A small control block turns the operation fields into a strobe struct, and a datapath block computes every candidate result and registers the selected one.

Top module: `xorrot_unit`

## Requirements
- R1: Operation code 2'b00 treats the vector as two 64-bit lanes; each lane result is `srcA ^ rotl(srcB, 1)` within that lane.
- R2: Operation code 2'b01 computes `srcA ^ srcB` and rotates each element right by the effective amount; element-size code 0, 1, 2, 3 selects 8, 16, 32, 64-bit elements.
- R3: The rotate amount is taken modulo the element width, so an amount of zero or of exactly the element width yields the plain `srcA ^ srcB`.
- R4: For 8-bit and 16-bit elements, bits leaving the low end of an element reenter at the high end of that same element and never reach a neighbouring element.
- R5: Operation code 2'b10 yields `srcA ^ srcB ^ srcC`.
- R6: Operation code 2'b11 yields `srcA ^ (srcB & ~srcC)`.
- R7: For operation codes 2'b00, 2'b10 and 2'b11 the element-size and rotate-amount inputs have no effect on the result.
- R8: `outValid` is high in exactly the cycle after a cycle with `inValid` high; `result` updates only on such a transfer and otherwise holds its value.
- R9: A synchronous active-low reset clears `outValid` and `result` to zero at the next clock edge.
- R10: For operation code 2'b01 a rotate amount above the element width is illegal; the largest legal amount, equal to the width, is accepted and behaves as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Operands and operation fields are valid this cycle |
| opSel | input | 2 | Operation code (see R1, R2, R5, R6) |
| elemSize | input | 2 | Element-size code for the XOR-rotate operation |
| rotAmt | input | 7 | Right-rotate amount for the XOR-rotate operation, 0 to element width |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| srcC | input | 128 | Third source vector |
| outValid | output | 1 | Result valid |
| result | output | 128 | Registered result vector |

## Verification
On every cycle the assertions check the valid handshake timing, the hold of the result between transfers, the reset clearing, the legality of the rotate amount, the three-way XOR result, and the fact that a zero effective rotate collapses to plain XOR. Per-element rotation at each size, the containment of wrapped bits inside 8-bit and 16-bit elements, the fixed one-bit rotate, the masked XOR, and the independence of the other operations from the size and amount inputs are shown only by the bench, which compares against a bit-index reference model and hand-computed literals.

// File: rtl/xr_pkg.sv
package xr_pkg;

  localparam int MAX_ELEM_W = 64;
  localparam int MIN_ELEM_W = 8;
  localparam int NUM_SIZES  = 4;
  localparam int AMT_W      = $clog2(MAX_ELEM_W) + 1;
  localparam int ROT_W      = $clog2(MAX_ELEM_W);

  typedef enum logic [1:0] {
    OP_RAX  = 2'b00,
    OP_XROT = 2'b01,
    OP_XOR3 = 2'b10,
    OP_BCLX = 2'b11
  } opKind_e;

  typedef struct packed {
    logic             load;
    opKind_e          op;
    logic [1:0]       size;
    logic [ROT_W-1:0] rotEff;
  } ctrlStb_t;

endpackage

// File: rtl/xr_ctrl.sv
module xr_ctrl
  import xr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [1:0]       elemSize,
  input  logic [AMT_W-1:0] rotAmt,
  output ctrlStb_t         stb
);

  logic [AMT_W-1:0] elemWidth;
  logic [AMT_W-1:0] widthMask;

  always_comb begin
    elemWidth = AMT_W'(MIN_ELEM_W) << elemSize;
    widthMask = elemWidth - AMT_W'(1);
  end

  always_comb begin
    stb.load   = inValid;
    stb.op     = opKind_e'(opSel);
    stb.size   = 2'd0;
    stb.rotEff = '0;
    if (opKind_e'(opSel) == OP_XROT) begin
      stb.size   = elemSize;
      stb.rotEff = ROT_W'(rotAmt & widthMask);
    end
  end

  // R10
  rot_amt_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_XROT) |-> (rotAmt <= elemWidth));

endmodule

// File: rtl/xr_datapath.sv
module xr_datapath
  import xr_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] srcC,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);

  localparam int RAX_LANE_W = MAX_ELEM_W;
  localparam int RAX_LANES  = VEC_W / RAX_LANE_W;

  logic [VEC_W-1:0] xorAB;
  logic [VEC_W-1:0] raxRes;
  logic [VEC_W-1:0] xor3Res;
  logic [VEC_W-1:0] bclxRes;
  logic [VEC_W-1:0] rotBySize [NUM_SIZES];
  logic [VEC_W-1:0] nextRes;

  assign xorAB   = srcA ^ srcB;
  assign xor3Res = xorAB ^ srcC;
  assign bclxRes = srcA ^ (srcB & ~srcC);

  // fixed one-bit left rotate per 64-bit lane
  for (genvar l = 0; l < RAX_LANES; l++) begin : gRaxLane
    assign raxRes[l*RAX_LANE_W +: RAX_LANE_W] =
      srcA[l*RAX_LANE_W +: RAX_LANE_W] ^
      {srcB[l*RAX_LANE_W +: RAX_LANE_W-1], srcB[l*RAX_LANE_W + RAX_LANE_W-1]};
  end

  // one rotator bank per element size, each element rotated in isolation
  for (genvar s = 0; s < NUM_SIZES; s++) begin : gSize
    localparam int EW = MIN_ELEM_W << s;
    localparam int EN = VEC_W / EW;
    localparam int SH = $clog2(EW);
    logic [SH-1:0] amt;
    assign amt = stb.rotEff[SH-1:0];
    for (genvar e = 0; e < EN; e++) begin : gElem
      logic [EW-1:0] elemIn;
      assign elemIn = xorAB[e*EW +: EW];
      assign rotBySize[s][e*EW +: EW] =
        (elemIn >> amt) | (elemIn << (EW - int'(amt)));
    end
  end

  always_comb begin
    unique case (stb.op)
      OP_RAX:  nextRes = raxRes;
      OP_XROT: nextRes = rotBySize[stb.size];
      OP_XOR3: nextRes = xor3Res;
      OP_BCLX: nextRes = bclxRes;
      default: nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= stb.load;
      if (stb.load) result <= nextRes;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> outValid);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> !outValid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && $past(rstN)) |=> $stable(result));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && result == '0));

  // R5
  xor3_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.op == OP_XOR3) |=> result == ($past(srcA) ^ $past(srcB) ^ $past(srcC)));

  // R3
  zero_rot_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.op == OP_XROT && stb.rotEff == '0) |=> result == ($past(srcA) ^ $past(srcB)));

endmodule

// File: rtl/xorrot_unit.sv
module xorrot_unit
  import xr_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [1:0]       elemSize,
  input  logic [AMT_W-1:0] rotAmt,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] srcC,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);

  ctrlStb_t stb;

  xr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .elemSize (elemSize),
    .rotAmt   (rotAmt),
    .stb      (stb)
  );

  xr_datapath #(.VEC_W(VEC_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .srcA     (srcA),
    .srcB     (srcB),
    .srcC     (srcC),
    .outValid (outValid),
    .result   (result)
  );

endmodule

// File: tb/tb_xorrot_unit.sv
module tb_xorrot_unit;

  localparam int VW = 128;
  localparam int EW = 2 + 2 + 7 + 3 * VW;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [1:0]    opSel = 2'd0;
  logic [1:0]    elemSize = 2'd0;
  logic [6:0]    rotAmt = 7'd0;
  logic [VW-1:0] srcA = '0;
  logic [VW-1:0] srcB = '0;
  logic [VW-1:0] srcC = '0;
  logic          outValid;
  logic [VW-1:0] result;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;

  xorrot_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .elemSize(elemSize), .rotAmt(rotAmt), .srcA(srcA), .srcB(srcB),
    .srcC(srcC), .outValid(outValid), .result(result)
  );

  // entry layout: {op, size, amount, a, b, c}
  localparam logic [EW-1:0] VECS [NV] = '{
    {2'd0, 2'd3, 7'd9,  128'h0123456789abcdef_fedcba9876543210, 128'h8000000000000001_7fffffffffffffff, 128'h0},
    {2'd0, 2'd1, 7'd40, 128'h0, {2{64'hf0f0f0f0_0f0f0f0f}}, {4{32'h5555aaaa}}},
    {2'd1, 2'd0, 7'd3,  {4{32'h12345678}}, {4{32'h9abcdef0}}, 128'h0},
    {2'd1, 2'd1, 7'd5,  {2{64'hdeadbeefcafef00d}}, {4{32'h00ff00ff}}, 128'h0},
    {2'd1, 2'd2, 7'd31, 128'h0011223344556677_8899aabbccddeeff, {4{32'h0f0f0f0f}}, 128'h0},
    {2'd1, 2'd3, 7'd1,  128'h1, 128'h0, 128'h0},
    {2'd1, 2'd3, 7'd64, 128'hfedcba9876543210_0123456789abcdef, {4{32'h33333333}}, 128'h0},
    {2'd1, 2'd0, 7'd8,  {4{32'hc3c3a5a5}}, {4{32'h0ff01234}}, 128'h0},
    {2'd2, 2'd0, 7'd0,  {4{32'h11111111}}, {4{32'h22224444}}, {4{32'h88880001}}},
    {2'd3, 2'd2, 7'd3,  {4{32'hffff0000}}, {4{32'hf0f0f0f0}}, {4{32'hcccccccc}}}
  };

  function automatic logic [VW-1:0] model(input logic [1:0] op, input logic [1:0] sz,
                                          input int amt, input logic [VW-1:0] a,
                                          input logic [VW-1:0] b, input logic [VW-1:0] c);
    logic [VW-1:0] r;
    logic [VW-1:0] x;
    int w;
    int k;
    int base;
    r = '0;
    x = a ^ b;
    case (op)
      2'd0: for (int i = 0; i < VW; i++) begin
        base = (i / 64) * 64;
        r[i] = a[i] ^ b[base + ((i - base + 63) % 64)];
      end
      2'd1: begin
        w = 8 << sz;
        k = amt % w;
        for (int i = 0; i < VW; i++) begin
          base = (i / w) * w;
          r[i] = x[base + ((i - base + k) % w)];
        end
      end
      2'd2: r = a ^ b ^ c;
      default: r = a ^ (b & ~c);
    endcase
    return r;
  endfunction

  function automatic string tagOf(input logic [1:0] op, input logic [1:0] sz, input int amt);
    if (op == 2'd0) return "R1";
    if (op == 2'd2) return "R5";
    if (op == 2'd3) return "R6";
    if (amt % (8 << sz) == 0) return "R3";
    if (sz < 2) return "R2 R4";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic present(input logic [1:0] op, input logic [1:0] sz, input logic [6:0] amt,
                         input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c);
    opSel = op; elemSize = sz; rotAmt = amt;
    srcA = a; srcB = b; srcC = c;
    inValid = 1'b1;
  endtask

  task automatic drive(input logic [1:0] op, input logic [1:0] sz, input logic [6:0] amt,
                       input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c);
    @(negedge clk);
    present(op, sz, amt, a, b, c);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    #800000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [VW-1:0] held;
    logic [VW-1:0] expA;
    logic [VW-1:0] expB;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset valid", VW'(outValid), VW'(0));
    check("R9 reset result", result, '0);
    rstN = 1'b1;

    for (int n = 0; n < NV; n++) begin
      logic [1:0] op;
      logic [1:0] sz;
      logic [6:0] amt;
      logic [VW-1:0] a, b, c;
      {op, sz, amt, a, b, c} = VECS[n];
      drive(op, sz, amt, a, b, c);
      check({tagOf(op, sz, int'(amt)), " valid"}, VW'(outValid), VW'(1));
      check(tagOf(op, sz, int'(amt)), result, model(op, sz, int'(amt), a, b, c));
    end

    // R4: byte elements keep wrapped bits inside the byte
    drive(2'd1, 2'd0, 7'd1, {16{8'h01}}, '0, '0);
    check("R4 byte wrap", result, {16{8'h80}});
    // R4: halfword elements
    drive(2'd1, 2'd1, 7'd4, {8{16'h000f}}, '0, '0);
    check("R4 half wrap", result, {8{16'hf000}});
    // R3: amount equal to 16-bit width
    drive(2'd1, 2'd1, 7'd16, {4{32'h1234abcd}}, {4{32'hffff0000}}, '0);
    check("R3 width amount", result, {4{32'h1234abcd}} ^ {4{32'hffff0000}});
    // R10: largest legal amount at 32-bit width accepted
    drive(2'd1, 2'd2, 7'd32, {4{32'h0badf00d}}, {4{32'h10203040}}, '0);
    check("R10 max amount", result, {4{32'h0badf00d}} ^ {4{32'h10203040}});

    // R7: size and amount ignored by other operations
    drive(2'd2, 2'd3, 7'd33, {4{32'h01234567}}, {4{32'h89abcdef}}, {4{32'h0f1e2d3c}});
    check("R7 xor3", result, {4{32'h01234567}} ^ {4{32'h89abcdef}} ^ {4{32'h0f1e2d3c}});
    drive(2'd3, 2'd0, 7'd7, {4{32'haaaa5555}}, {4{32'hff00ff00}}, {4{32'h0ff00ff0}});
    check("R7 bclx", result, {4{32'haaaa5555}} ^ ({4{32'hff00ff00}} & ~{4{32'h0ff00ff0}}));
    drive(2'd0, 2'd0, 7'd5, 128'h0, 128'h1, 128'h0);
    check("R7 rax", result, 128'h2);

    // R8: result holds while idle
    held = result;
    repeat (3) @(negedge clk);
    check("R8 idle valid", VW'(outValid), VW'(0));
    check("R8 hold", result, held);

    // R8: back-to-back transfers
    expA = {4{32'h11110000}} ^ {4{32'h00002222}};
    expB = {4{32'h0000ffff}};
    @(negedge clk);
    present(2'd1, 2'd3, 7'd0, {4{32'h11110000}}, {4{32'h00002222}}, '0);
    @(negedge clk);
    check("R8 first", result, expA);
    present(2'd2, 2'd0, 7'd0, {4{32'h0000ffff}}, '0, '0);
    @(negedge clk);
    inValid = 1'b0;
    check("R8 second", result, expB);
    check("R8 second valid", VW'(outValid), VW'(1));

    // R9: reset wins over a valid input
    @(negedge clk);
    present(2'd2, 2'd0, 7'd0, {4{32'hdeadbeef}}, '0, '0);
    rstN = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 mid valid", VW'(outValid), VW'(0));
    check("R9 mid result", result, '0);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end

endmodule